// File: doc/BRIEF.md
# Single-Operand Execution Unit with Condition Flags

This unit executes the one-operand arithmetic, logic, shift and status-transfer operations of a 16-bit minicomputer-style instruction set. The surrounding pipeline decodes the addressing mode, fetches the destination operand, and then presents three things together with a valid strobe: the instruction word, the fetched operand and the current processor status word. One clock later the unit returns the value to write back, a write enable and the new status word. The status word carries the updated N, Z, V and C flags.

The instruction word selects the operation and chooses between byte and word width. Each operation has its own rule for every flag. Byte forms test overflow and sign at bit 7, and word forms test them at bit 15. For byte forms, a register destination keeps its upper byte. The only exception is reading the status byte into a register, which sign-extends it. The unit does no address generation, no memory access and no stack handling.

Top module: `sop_alu`

## Requirements
- R1: Instruction fields: bit 15 selects byte width, bits 14:6 are the opcode, bits 5:3 are the destination mode (0 means register), and bits 2:0 are the register. Opcodes: 0o050 clear, 0o051 complement, 0o052 increment, 0o053 decrement, 0o054 negate, 0o055 add carry, 0o056 subtract carry, 0o057 test, 0o060 rotate right, 0o061 rotate left, 0o062 arithmetic shift right, 0o063 shift left, 0o064 byte-only status load, 0o067 (sign extend as word, status store as byte), and 0o003 word-only byte swap. Results appear one clock after `valid_i` is sampled high, and `valid_o` marks them.
- R2: Clear writes zero and sets the flags N=0, Z=1, V=0, C=0.
- R3: Increment and decrement wrap within the selected width and leave C unchanged. Increment sets V only when the operand was 0x7F (byte) or 0x7FFF (word). Decrement sets V only when the operand was 0x80 (byte) or 0x8000 (word).
- R4: Negate writes the two's complement. V=1 exactly when the result is the most negative value, and C=1 exactly when the result is nonzero.
- R5: Add carry writes operand+C. It sets V when the operand was the largest positive value and C was 1, and sets C when the operand was all ones and C was 1. Subtract carry writes operand−C. It sets V when the operand was the most negative value and C was 1, and sets C when the operand was zero and C was 1.
- R6: Complement writes the bitwise inverse and sets V=0, C=1. Test writes nothing, takes N and Z from the operand, and clears V and C.
- R7: Rotates pass through C. Rotate and shift right load C from the old bit 0, and the left forms load C from the old sign bit. Arithmetic shift right keeps the sign bit. For all four, V = N xor C after the operation.
- R8: Byte swap exchanges the two halves of the word. N and Z come from the new low byte, and V and C are cleared.
- R9: Sign extend writes all ones when N is set and zero otherwise. It sets Z to the inverse of N, clears V, and leaves N and C unchanged.
- R10: Status load replaces only status bits 7:0 with the operand's low byte and writes nothing. Status store writes the status low byte, sets N and Z from it, clears V and keeps C. For a register destination it sign-extends the byte to 16 bits.
- R11: Apart from status store into a register, a byte operation returns `result_o[15:8]` equal to `operand_i[15:8]`.
- R12: Any unlisted opcode or width combination gives write enable 0, the result equal to the operand, and the status word unchanged.
- R13: The flags sit in status bits N=3, Z=2, V=1, C=0. Status bits 15:4 pass through unchanged for every operation except status load.
- R14: Under reset all outputs are zero. A cycle with `valid_i` low drops `valid_o` and holds `result_o`, `wr_en_o` and `psw_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on the inputs |
| instr_i | input | 16 | Instruction word |
| operand_i | input | 16 | Fetched destination value |
| psw_i | input | 16 | Current processor status word |
| valid_o | output | 1 | Outputs hold a new result |
| result_o | output | 16 | Value to write back |
| wr_en_o | output | 1 | Destination must be written |
| psw_o | output | 16 | Updated status word |

## Verification
The assertions assume that `instr_i`, `operand_i` and `psw_i` are known and stable whenever `valid_i` is sampled high. They also assume the operand has already been fetched at the width the instruction asks for. The stimulus changes inputs only on the falling edge, sets every field explicitly, and keeps the upper status bits at non-zero patterns so that any leak into them shows up. Opcodes outside the list are applied on purpose to exercise the pass-through rule.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 9;

  localparam logic [OPC_W-1:0] OPC_CLR  = 9'o050;
  localparam logic [OPC_W-1:0] OPC_COM  = 9'o051;
  localparam logic [OPC_W-1:0] OPC_INC  = 9'o052;
  localparam logic [OPC_W-1:0] OPC_DEC  = 9'o053;
  localparam logic [OPC_W-1:0] OPC_NEG  = 9'o054;
  localparam logic [OPC_W-1:0] OPC_ADC  = 9'o055;
  localparam logic [OPC_W-1:0] OPC_SBC  = 9'o056;
  localparam logic [OPC_W-1:0] OPC_TST  = 9'o057;
  localparam logic [OPC_W-1:0] OPC_ROR  = 9'o060;
  localparam logic [OPC_W-1:0] OPC_ROL  = 9'o061;
  localparam logic [OPC_W-1:0] OPC_ASR  = 9'o062;
  localparam logic [OPC_W-1:0] OPC_ASL  = 9'o063;
  localparam logic [OPC_W-1:0] OPC_STLD = 9'o064;
  localparam logic [OPC_W-1:0] OPC_SXST = 9'o067;
  localparam logic [OPC_W-1:0] OPC_SWAB = 9'o003;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_W = 4;

  typedef enum logic [4:0] {
    OP_NONE, OP_CLR, OP_COM, OP_INC, OP_DEC, OP_NEG, OP_ADC, OP_SBC,
    OP_TST, OP_ROR, OP_ROL, OP_ASR, OP_ASL, OP_SWAB, OP_SXT,
    OP_STST, OP_STLD
  } op_e;

  typedef struct packed {
    op_e  op;
    logic byte_sel;
    logic reg_dst;
    logic writes;
  } dec_t;
endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [OPC_W-1:0] opc;
  logic             bsel;
  op_e              op;

  assign opc  = instr_i[14:6];
  assign bsel = instr_i[15];

  always_comb begin
    op = OP_NONE;
    unique case (opc)
      OPC_CLR:  op = OP_CLR;
      OPC_COM:  op = OP_COM;
      OPC_INC:  op = OP_INC;
      OPC_DEC:  op = OP_DEC;
      OPC_NEG:  op = OP_NEG;
      OPC_ADC:  op = OP_ADC;
      OPC_SBC:  op = OP_SBC;
      OPC_TST:  op = OP_TST;
      OPC_ROR:  op = OP_ROR;
      OPC_ROL:  op = OP_ROL;
      OPC_ASR:  op = OP_ASR;
      OPC_ASL:  op = OP_ASL;
      OPC_STLD: op = bsel ? OP_STLD : OP_NONE;
      OPC_SXST: op = bsel ? OP_STST : OP_SXT;
      OPC_SWAB: op = bsel ? OP_NONE : OP_SWAB;
      default:  op = OP_NONE;
    endcase
  end

  assign dec_o.op       = op;
  assign dec_o.byte_sel = bsel;
  assign dec_o.reg_dst  = (instr_i[5:3] == 3'd0);
  assign dec_o.writes   = !(op inside {OP_NONE, OP_TST, OP_STLD});
endmodule

// File: rtl/sop_lane.sv
module sop_lane
  import sop_pkg::*;
#(
  parameter int LW = 8
) (
  input  op_e           op_i,
  input  logic [LW-1:0] a_i,
  input  logic          c_i,
  output logic [LW-1:0] r_o,
  output logic [FLG_W-1:0] flg_o
);
  localparam logic [LW-1:0] MSB_V  = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] MAXP_V = ~MSB_V;
  localparam logic [LW-1:0] ONES_V = '1;
  localparam logic [LW-1:0] ONE_V  = {{(LW-1){1'b0}}, 1'b1};
  localparam logic [LW-1:0] CIN0   = '0;

  logic [LW-1:0] r;
  logic          v, c, shf;
  logic [LW-1:0] cin_w;

  assign cin_w = c_i ? ONE_V : CIN0;

  always_comb begin
    r   = a_i;
    v   = 1'b0;
    c   = c_i;
    shf = 1'b0;
    case (op_i)
      OP_CLR: begin r = '0; c = 1'b0; end
      OP_COM: begin r = ~a_i; c = 1'b1; end
      OP_INC: begin r = a_i + ONE_V; v = (a_i == MAXP_V); end
      OP_DEC: begin r = a_i - ONE_V; v = (a_i == MSB_V); end
      OP_NEG: begin
        r = CIN0 - a_i;
        v = (r == MSB_V);
        c = (r != '0);
      end
      OP_ADC: begin
        r = a_i + cin_w;
        v = c_i && (a_i == MAXP_V);
        c = c_i && (a_i == ONES_V);
      end
      OP_SBC: begin
        r = a_i - cin_w;
        v = c_i && (a_i == MSB_V);
        c = c_i && (a_i == '0);
      end
      OP_TST: c = 1'b0;
      OP_ROR: begin r = {c_i, a_i[LW-1:1]};     c = a_i[0];    shf = 1'b1; end
      OP_ROL: begin r = {a_i[LW-2:0], c_i};     c = a_i[LW-1]; shf = 1'b1; end
      OP_ASR: begin r = {a_i[LW-1], a_i[LW-1:1]}; c = a_i[0];  shf = 1'b1; end
      OP_ASL: begin r = {a_i[LW-2:0], 1'b0};    c = a_i[LW-1]; shf = 1'b1; end
      default: ;
    endcase
    if (shf) v = r[LW-1] ^ c;
  end

  assign r_o = r;
  always_comb begin
    flg_o        = '0;
    flg_o[FLG_N] = r[LW-1];
    flg_o[FLG_Z] = (r == '0);
    flg_o[FLG_V] = v;
    flg_o[FLG_C] = c;
  end
endmodule

// File: rtl/sop_exec.sv
module sop_exec
  import sop_pkg::*;
#(
  parameter int W = 16
) (
  input  dec_t         dec_i,
  input  logic [W-1:0] operand_i,
  input  logic [W-1:0] psw_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [W-1:0] psw_o
);
  localparam int HALF   = W / 2;
  localparam int NLANES = 2;

  logic [W-1:0]     lane_r [NLANES];
  logic [FLG_W-1:0] lane_f [NLANES];

  // lane 0 = byte width, lane 1 = word width
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? HALF : W;
    logic [LW-1:0]    r;
    logic [FLG_W-1:0] f;
    sop_lane #(.LW(LW)) u_lane (
      .op_i  (dec_i.op),
      .a_i   (operand_i[LW-1:0]),
      .c_i   (psw_i[FLG_C]),
      .r_o   (r),
      .flg_o (f)
    );
    assign lane_r[g] = W'(r);
    assign lane_f[g] = f;
  end

  logic [W-1:0]     r;
  logic [FLG_W-1:0] f;
  logic [W-1:0]     psw_n;
  logic [HALF-1:0]  st_lo;

  assign st_lo = psw_i[HALF-1:0];

  always_comb begin
    r = dec_i.byte_sel ? lane_r[0] : lane_r[1];
    f = dec_i.byte_sel ? lane_f[0] : lane_f[1];
    case (dec_i.op)
      OP_SWAB: begin
        r = {operand_i[HALF-1:0], operand_i[W-1:HALF]};
        f = '0;
        f[FLG_N] = operand_i[W-1];
        f[FLG_Z] = (operand_i[W-1:HALF] == '0);
      end
      OP_SXT: begin
        r = psw_i[FLG_N] ? '1 : '0;
        f = '0;
        f[FLG_N] = psw_i[FLG_N];
        f[FLG_Z] = !psw_i[FLG_N];
        f[FLG_C] = psw_i[FLG_C];
      end
      OP_STST: begin
        r = W'(st_lo);
        f = '0;
        f[FLG_N] = st_lo[HALF-1];
        f[FLG_Z] = (st_lo == '0);
        f[FLG_C] = psw_i[FLG_C];
      end
      default: ;
    endcase
  end

  always_comb begin
    psw_n = {psw_i[W-1:FLG_W], f};
    if (dec_i.op == OP_STLD) psw_n = {psw_i[W-1:HALF], operand_i[HALF-1:0]};
    else if (dec_i.op == OP_NONE) psw_n = psw_i;
  end

  always_comb begin
    if (!dec_i.writes)
      result_o = operand_i;
    else if (!dec_i.byte_sel)
      result_o = r;
    else if (dec_i.op == OP_STST && dec_i.reg_dst)
      result_o = {{HALF{r[HALF-1]}}, r[HALF-1:0]};
    else
      result_o = {operand_i[W-1:HALF], r[HALF-1:0]};
  end

  assign wr_en_o = dec_i.writes;
  assign psw_o   = psw_n;
endmodule

// File: rtl/sop_stage.sv
module sop_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] result_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] psw_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [W-1:0] psw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      wr_en_o  <= 1'b0;
      psw_o    <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        result_o <= result_i;
        wr_en_o  <= wr_en_i;
        psw_o    <= psw_i;
      end
    end
  end

  assert_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o && $stable(result_o) && $stable(psw_o) && $stable(wr_en_o));
endmodule

// File: rtl/sop_alu.sv
module sop_alu
  import sop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [15:0]  instr_i,
  input  logic [W-1:0] operand_i,
  input  logic [W-1:0] psw_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [W-1:0] psw_o
);
  localparam int HALF = W / 2;

  dec_t         dec;
  logic [W-1:0] ex_res;
  logic         ex_wr;
  logic [W-1:0] ex_psw;

  sop_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  sop_exec #(.W(W)) u_exec (
    .dec_i     (dec),
    .operand_i (operand_i),
    .psw_i     (psw_i),
    .result_o  (ex_res),
    .wr_en_o   (ex_wr),
    .psw_o     (ex_psw)
  );

  sop_stage #(.W(W)) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (valid_i),
    .result_i (ex_res),
    .wr_en_i  (ex_wr),
    .psw_i    (ex_psw),
    .valid_o  (valid_o),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .psw_o    (psw_o)
  );

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_clr_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[14:6] == OPC_CLR |=> psw_o[3:0] == 4'b0100 && wr_en_o);

  assert_inc_ovf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !instr_i[15] && instr_i[14:6] == OPC_INC && operand_i == 16'h7FFF
    |=> psw_o[FLG_V] && psw_o[FLG_N] && result_o == 16'h8000);

  assert_tst_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[14:6] == OPC_TST |=> !wr_en_o && !psw_o[FLG_V] && !psw_o[FLG_C]);

  assert_byte_upper_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[15] && !(instr_i[14:6] == OPC_SXST && instr_i[5:3] == 3'd0)
    |=> result_o[W-1:HALF] == $past(operand_i[W-1:HALF]));

  assert_psw_high_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> psw_o[W-1:HALF] == $past(psw_i[W-1:HALF]));
endmodule

// File: tb/sim_sop_alu.sv
module sim_sop_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 40;
  localparam int WATCHDOG = 20000;

  // {tag, instr, operand, psw_in, exp_result, exp_wr, exp_psw}
  typedef logic [24+16*5:0] vec_t;

  localparam vec_t VEC [NV] = '{
    {"R2 ", 16'h0A00, 16'h1234, 16'h12EF, 16'h0000, 1'b1, 16'h12E4},
    {"R2 ", 16'h8A00, 16'h1234, 16'h12E0, 16'h1200, 1'b1, 16'h12E4},
    {"R6 ", 16'h0A40, 16'h00FF, 16'h12E0, 16'hFF00, 1'b1, 16'h12E9},
    {"R3 ", 16'h0A80, 16'h7FFF, 16'h12E1, 16'h8000, 1'b1, 16'h12EB},
    {"R3 ", 16'h8A80, 16'h127F, 16'h12E0, 16'h1280, 1'b1, 16'h12EA},
    {"R3 ", 16'h8A80, 16'h00FF, 16'h12E0, 16'h0000, 1'b1, 16'h12E4},
    {"R3 ", 16'h0AC0, 16'h8000, 16'h12E0, 16'h7FFF, 1'b1, 16'h12E2},
    {"R3 ", 16'h8AC0, 16'hAB00, 16'h12E1, 16'hABFF, 1'b1, 16'h12E9},
    {"R4 ", 16'h0B00, 16'h0001, 16'h12E0, 16'hFFFF, 1'b1, 16'h12E9},
    {"R4 ", 16'h0B00, 16'h8000, 16'h12E0, 16'h8000, 1'b1, 16'h12EB},
    {"R4 ", 16'h8B00, 16'h0000, 16'h12EF, 16'h0000, 1'b1, 16'h12E4},
    {"R5 ", 16'h0B40, 16'h7FFF, 16'h12E1, 16'h8000, 1'b1, 16'h12EA},
    {"R5 ", 16'h0B40, 16'hFFFF, 16'h12E1, 16'h0000, 1'b1, 16'h12E5},
    {"R5 ", 16'h0B40, 16'h7FFF, 16'h12E0, 16'h7FFF, 1'b1, 16'h12E0},
    {"R5 ", 16'h0B80, 16'h0000, 16'h12E1, 16'hFFFF, 1'b1, 16'h12E9},
    {"R5 ", 16'h8B80, 16'h0080, 16'h12E1, 16'h007F, 1'b1, 16'h12E2},
    {"R6 ", 16'h0BC0, 16'h8000, 16'h12E3, 16'h8000, 1'b0, 16'h12E8},
    {"R6 ", 16'h8BC0, 16'h0100, 16'h12E0, 16'h0100, 1'b0, 16'h12E4},
    {"R7 ", 16'h0C00, 16'h0001, 16'h12E0, 16'h0000, 1'b1, 16'h12E7},
    {"R7 ", 16'h0C00, 16'h0002, 16'h12E1, 16'h8001, 1'b1, 16'h12EA},
    {"R7 ", 16'h8C40, 16'h1280, 16'h12E0, 16'h1200, 1'b1, 16'h12E7},
    {"R7 ", 16'h0C40, 16'h4000, 16'h12E1, 16'h8001, 1'b1, 16'h12EA},
    {"R7 ", 16'h0C80, 16'h8003, 16'h12E0, 16'hC001, 1'b1, 16'h12E9},
    {"R7 ", 16'h8C80, 16'h0040, 16'h12E0, 16'h0020, 1'b1, 16'h12E0},
    {"R7 ", 16'h0CC0, 16'h4000, 16'h12E0, 16'h8000, 1'b1, 16'h12EA},
    {"R7 ", 16'h8CC0, 16'h5580, 16'h12E0, 16'h5500, 1'b1, 16'h12E7},
    {"R8 ", 16'h00C0, 16'h80FF, 16'h12E3, 16'hFF80, 1'b1, 16'h12E8},
    {"R8 ", 16'h00C0, 16'h00FF, 16'h12E0, 16'hFF00, 1'b1, 16'h12E4},
    {"R9 ", 16'h0DC0, 16'h1234, 16'h12E8, 16'hFFFF, 1'b1, 16'h12E8},
    {"R9 ", 16'h0DC0, 16'h1234, 16'h12E3, 16'h0000, 1'b1, 16'h12E5},
    {"R10", 16'h8D00, 16'h3C05, 16'h12E0, 16'h3C05, 1'b0, 16'h1205},
    {"R10", 16'h8D00, 16'h0008, 16'hFF00, 16'h0008, 1'b0, 16'hFF08},
    {"R10", 16'h8DC0, 16'h4444, 16'h12E1, 16'hFFE1, 1'b1, 16'h12E9},
    {"R11", 16'h8DC8, 16'h4444, 16'h1201, 16'h4401, 1'b1, 16'h1201},
    {"R10", 16'h8DC0, 16'h4444, 16'h1201, 16'h0001, 1'b1, 16'h1201},
    {"R12", 16'h0000, 16'h5555, 16'h12EA, 16'h5555, 1'b0, 16'h12EA},
    {"R12", 16'h80C0, 16'h5555, 16'h12E5, 16'h5555, 1'b0, 16'h12E5},
    {"R12", 16'h0D00, 16'h7777, 16'h12E0, 16'h7777, 1'b0, 16'h12E0},
    {"R11", 16'h8A40, 16'h12F0, 16'h12E0, 16'h120F, 1'b1, 16'h12E1},
    {"R13", 16'h8A00, 16'hA5C3, 16'h5A9F, 16'hA500, 1'b1, 16'h5A94}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [15:0] instr_i, operand_i, psw_i;
  logic        valid_o, wr_en_o;
  logic [15:0] result_o, psw_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sop_alu u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .operand_i (operand_i),
    .psw_i     (psw_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .wr_en_o   (wr_en_o),
    .psw_o     (psw_o)
  );

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual v/wr/res/psw=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0;
    instr_i = '0; operand_i = '0; psw_i = '0;
    repeat (3) @(negedge clk_i);
    // R14 reset state
    chk("R14", {valid_o, wr_en_o, result_o, psw_o}, 34'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R14", {valid_o, wr_en_o, result_o, psw_o}, 34'h0);

    // R1 one-cycle latency, back-to-back vectors
    for (int i = 0; i < NV; i++) begin
      valid_i   = 1'b1;
      instr_i   = VEC[i][80:65];
      operand_i = VEC[i][64:49];
      psw_i     = VEC[i][48:33];
      @(negedge clk_i);
      chk(string'(VEC[i][104:81]),
          {valid_o, wr_en_o, result_o, psw_o},
          {1'b1, VEC[i][16], VEC[i][32:17], VEC[i][15:0]});
    end

    // R14 hold with valid_i low while inputs move
    valid_i = 1'b0; instr_i = 16'h0A00; operand_i = 16'hFFFF; psw_i = 16'h0000;
    @(negedge clk_i);
    chk("R14", {valid_o, wr_en_o, result_o, psw_o}, {1'b0, 1'b1, 16'hA500, 16'h5A94});
    @(negedge clk_i);
    chk("R14", {valid_o, wr_en_o, result_o, psw_o}, {1'b0, 1'b1, 16'hA500, 16'h5A94});

    // R1 single issue after idle
    valid_i = 1'b1; instr_i = 16'h0A80; operand_i = 16'h0041; psw_i = 16'h0000;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R1", {valid_o, wr_en_o, result_o, psw_o}, {1'b1, 1'b1, 16'h0042, 16'h0000});
    @(negedge clk_i);
    chk("R1", {valid_o, wr_en_o, result_o, psw_o}, {1'b0, 1'b1, 16'h0042, 16'h0000});

    // R14 asynchronous reset clears outputs mid-run
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1;
    chk("R14", {valid_o, wr_en_o, result_o, psw_o}, 34'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R14 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule